// File: doc/BRIEF.md
# Main Control Decoder for a Single-Cycle RV32I Subset

This block turns the 7-bit major opcode of an instruction into the control bits for a single-cycle datapath. The datapath supports R-type arithmetic, add-immediate, word load, word store, branch-if-equal, jump-and-link and register-indirect jump-and-link. The block has no clock and no state. Every output is a pure function of the opcode present on the input in the same cycle. The surrounding datapath registers the instruction and uses these bits to steer the operand mux, the memory strobes, the writeback source and the next-PC selection.

Ten control bits come out of the block, both as named outputs and as one packed bus. The bus lets a pipeline register or a debug tap capture them in a single field. A separate flag marks any opcode outside the seven supported ones. For such an opcode every control bit is forced low, so an unknown instruction can neither write a register, touch memory nor redirect the PC.

The 2-bit ALU class field tells the secondary ALU-control stage what to do:
- 00 means add, used for address and target arithmetic.
- 01 means subtract or compare, used by branches.
- 10 means decode both funct3 and funct7, used by register-register operations.
- 11 means decode funct3 only, used by immediate arithmetic.

Top module: `rv_main_ctrl`

## Requirements
- R1: Opcode 0110011 (register-register) gives reg_wr_o=1 and alu_op_o=10, with every other control bit 0.
- R2: Opcode 0010011 (add-immediate) gives alu_src_o=1, reg_wr_o=1 and alu_op_o=11, with every other control bit 0.
- R3: Opcode 0000011 (load word) gives alu_src_o=1, mem_to_reg_o=1, reg_wr_o=1 and mem_rd_o=1, with alu_op_o=00 and every other bit 0.
- R4: Opcode 0100011 (store word) gives alu_src_o=1 and mem_wr_o=1, with reg_wr_o=0, alu_op_o=00 and every other bit 0.
- R5: Opcode 1100011 (branch-if-equal) gives branch_o=1 and alu_op_o=01, with every other bit 0.
- R6: Opcode 1101111 (jump-and-link) gives jump_o=1 and reg_wr_o=1, with alu_op_o=00 and every other bit 0.
- R7: Opcode 1100111 (register jump-and-link) gives jump_reg_o=1, reg_wr_o=1 and alu_src_o=1, with alu_op_o=00 and every other bit 0.
- R8: Any of the other 121 opcode values drives all ten control bits to 0 and illegal_o to 1. The seven listed opcodes drive illegal_o to 0.
- R9: ctrl_bus_o, from bit 9 down to bit 0, equals {alu_src_o, mem_to_reg_o, reg_wr_o, mem_rd_o, mem_wr_o, branch_o, jump_o, jump_reg_o, alu_op_o[1:0]}.
- R10: At most one of branch_o, jump_o and jump_reg_o is 1, and mem_rd_o and mem_wr_o are never 1 together, for every opcode.
- R11: The outputs settle within the same cycle the opcode is applied, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 7 | Major opcode field of the current instruction |
| alu_src_o | output | 1 | Second ALU operand comes from the immediate |
| mem_to_reg_o | output | 1 | Writeback data comes from memory |
| reg_wr_o | output | 1 | Register file write enable |
| mem_rd_o | output | 1 | Data memory read strobe |
| mem_wr_o | output | 1 | Data memory write strobe |
| branch_o | output | 1 | Conditional branch instruction |
| jump_o | output | 1 | PC-relative unconditional jump |
| jump_reg_o | output | 1 | Register-indirect jump |
| alu_op_o | output | 2 | ALU class for the secondary ALU-control stage |
| ctrl_bus_o | output | 10 | All ten control bits packed in fixed order |
| illegal_o | output | 1 | Opcode is not one of the seven supported |

## Verification
The bench checks every supported opcode against its full ten-bit pattern, and then sweeps all 128 opcode values.

The sweep catches a decoder that matches on only part of the opcode. Such a decoder would accept a near-miss code, for example one differing in a single low bit, as a real instruction and assert a write strobe. The sweep also catches a default arm that leaves a stale bit high or fails to raise the illegal flag.

Comparing each named output against its bus bit exposes a swapped field order, such as alu_op reversed or the two jump bits exchanged. The register-indirect jump is checked for its operand-select bit, because leaving it at 0 would send rs1 plus rs2 to the target adder instead of rs1 plus the immediate.

// File: rtl/rv_main_ctrl_pkg.sv
package rv_main_ctrl_pkg;

  localparam int unsigned OPC_W     = 7;
  localparam int unsigned ALUOP_W   = 2;
  localparam int unsigned NUM_CLASS = 7;
  localparam int unsigned CTRL_W    = 8 + ALUOP_W;

  // ALU class codes handed to the secondary ALU-control stage
  localparam logic [ALUOP_W-1:0] ALUOP_ADD   = 2'b00;
  localparam logic [ALUOP_W-1:0] ALUOP_CMP   = 2'b01;
  localparam logic [ALUOP_W-1:0] ALUOP_RFULL = 2'b10;
  localparam logic [ALUOP_W-1:0] ALUOP_RIMM  = 2'b11;

  // instruction class indices
  localparam int unsigned CL_REG    = 0;
  localparam int unsigned CL_IMM    = 1;
  localparam int unsigned CL_LOAD   = 2;
  localparam int unsigned CL_STORE  = 3;
  localparam int unsigned CL_BRANCH = 4;
  localparam int unsigned CL_JAL    = 5;
  localparam int unsigned CL_JALR   = 6;

  localparam logic [OPC_W-1:0] CLASS_OPC [NUM_CLASS] = '{
    7'b0110011,  // register-register
    7'b0010011,  // add-immediate
    7'b0000011,  // load word
    7'b0100011,  // store word
    7'b1100011,  // branch-if-equal
    7'b1101111,  // jump-and-link
    7'b1100111   // register jump-and-link
  };

  // field order is the packed bus order, MSB first
  typedef struct packed {
    logic               alu_src;
    logic               mem_to_reg;
    logic               reg_wr;
    logic               mem_rd;
    logic               mem_wr;
    logic               branch;
    logic               jump;
    logic               jump_reg;
    logic [ALUOP_W-1:0] alu_op;
  } ctrl_t;

  function automatic ctrl_t class_ctrl(input int unsigned cls);
    ctrl_t c;
    c = '0;
    case (cls)
      CL_REG: begin
        c.reg_wr = 1'b1;
        c.alu_op = ALUOP_RFULL;
      end
      CL_IMM: begin
        c.alu_src = 1'b1;
        c.reg_wr  = 1'b1;
        c.alu_op  = ALUOP_RIMM;
      end
      CL_LOAD: begin
        c.alu_src    = 1'b1;
        c.mem_to_reg = 1'b1;
        c.reg_wr     = 1'b1;
        c.mem_rd     = 1'b1;
        c.alu_op     = ALUOP_ADD;
      end
      CL_STORE: begin
        c.alu_src = 1'b1;
        c.mem_wr  = 1'b1;
        c.alu_op  = ALUOP_ADD;
      end
      CL_BRANCH: begin
        c.branch = 1'b1;
        c.alu_op = ALUOP_CMP;
      end
      CL_JAL: begin
        c.jump   = 1'b1;
        c.reg_wr = 1'b1;
        c.alu_op = ALUOP_ADD;
      end
      CL_JALR: begin
        c.jump_reg = 1'b1;
        c.reg_wr   = 1'b1;
        c.alu_src  = 1'b1;
        c.alu_op   = ALUOP_ADD;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/rv_opc_classify.sv
module rv_opc_classify
  import rv_main_ctrl_pkg::*;
(
  input  logic [OPC_W-1:0]     opcode_i,
  output logic [NUM_CLASS-1:0] hit_o,
  output logic                 illegal_o
);

  // one full-width comparator per supported class
  for (genvar g = 0; g < NUM_CLASS; g++) begin : g_cmp
    assign hit_o[g] = (opcode_i == CLASS_OPC[g]);
  end

  assign illegal_o = ~|hit_o;

endmodule

// File: rtl/rv_ctrl_build.sv
module rv_ctrl_build
  import rv_main_ctrl_pkg::*;
(
  input  logic [NUM_CLASS-1:0] hit_i,
  output ctrl_t                ctrl_o
);

  // OR together the pattern of whichever class hit; no hit gives all zero
  always_comb begin
    ctrl_o = '0;
    for (int i = 0; i < NUM_CLASS; i++) begin
      if (hit_i[i]) ctrl_o = ctrl_o | class_ctrl(i);
    end
  end

  // the classifier must never report two classes at once (R8)
  always_comb begin
    assert_single_class_R8: assert ($onehot0(hit_i))
      else $error("more than one instruction class matched");
  end

endmodule

// File: rtl/rv_main_ctrl.sv
module rv_main_ctrl
  import rv_main_ctrl_pkg::*;
(
  input  logic [6:0] opcode_i,
  output logic       alu_src_o,
  output logic       mem_to_reg_o,
  output logic       reg_wr_o,
  output logic       mem_rd_o,
  output logic       mem_wr_o,
  output logic       branch_o,
  output logic       jump_o,
  output logic       jump_reg_o,
  output logic [1:0] alu_op_o,
  output logic [9:0] ctrl_bus_o,
  output logic       illegal_o
);

  logic [NUM_CLASS-1:0] hit;
  logic                 illegal;
  ctrl_t                ctrl;

  rv_opc_classify u_classify (
    .opcode_i  (opcode_i),
    .hit_o     (hit),
    .illegal_o (illegal)
  );

  rv_ctrl_build u_build (
    .hit_i  (hit),
    .ctrl_o (ctrl)
  );

  assign ctrl_bus_o   = ctrl;
  assign alu_src_o    = ctrl.alu_src;
  assign mem_to_reg_o = ctrl.mem_to_reg;
  assign reg_wr_o     = ctrl.reg_wr;
  assign mem_rd_o     = ctrl.mem_rd;
  assign mem_wr_o     = ctrl.mem_wr;
  assign branch_o     = ctrl.branch;
  assign jump_o       = ctrl.jump;
  assign jump_reg_o   = ctrl.jump_reg;
  assign alu_op_o     = ctrl.alu_op;
  assign illegal_o    = illegal;

  always_comb begin
    // unknown opcode must leave every control bit low (R8)
    assert_illegal_quiet_R8: assert (!illegal || (ctrl == '0))
      else $error("control asserted for illegal opcode");
    // a recognised opcode always asserts some control bit (R8)
    assert_legal_active_R8: assert (illegal || (ctrl != '0))
      else $error("legal opcode produced empty control word");
    // PC-redirect sources are mutually exclusive (R10)
    assert_one_redirect_R10: assert ($onehot0({ctrl.branch, ctrl.jump, ctrl.jump_reg}))
      else $error("more than one PC redirect asserted");
    // memory strobes are mutually exclusive (R10)
    assert_mem_excl_R10: assert (!(ctrl.mem_rd && ctrl.mem_wr))
      else $error("memory read and write both asserted");
    // memory writeback only with a read (R3)
    assert_wb_needs_read_R3: assert (!ctrl.mem_to_reg || ctrl.mem_rd)
      else $error("memory writeback selected without a read");
    // stores never write the register file (R4)
    assert_store_no_wr_R4: assert (!ctrl.mem_wr || !ctrl.reg_wr)
      else $error("store also writes register file");
  end

endmodule

// File: tb/sim_rv_main_ctrl.sv
`timescale 1ns/1ps
module sim_rv_main_ctrl;

  logic       clk;
  logic       rst_n;
  logic [6:0] opcode;
  logic       alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr;
  logic       branch, jump, jump_reg, illegal;
  logic [1:0] alu_op;
  logic [9:0] bus;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  rv_main_ctrl u0 (
    .opcode_i     (opcode),
    .alu_src_o    (alu_src),
    .mem_to_reg_o (mem_to_reg),
    .reg_wr_o     (reg_wr),
    .mem_rd_o     (mem_rd),
    .mem_wr_o     (mem_wr),
    .branch_o     (branch),
    .jump_o       (jump),
    .jump_reg_o   (jump_reg),
    .alu_op_o     (alu_op),
    .ctrl_bus_o   (bus),
    .illegal_o    (illegal)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {opcode, expected bus, requirement number}
  localparam int NV = 7;
  localparam logic [6:0] V_OPC [NV] = '{7'b0110011, 7'b0010011, 7'b0000011,
                                        7'b0100011, 7'b1100011, 7'b1101111,
                                        7'b1100111};
  // bus bit 9..0 = src, m2r, rw, mrd, mwr, br, j, jr, op[1:0]
  localparam logic [9:0] V_BUS [NV] = '{10'b0010000010,   // R1
                                        10'b1010000011,   // R2
                                        10'b1111000000,   // R3
                                        10'b1000100000,   // R4
                                        10'b0000010001,   // R5
                                        10'b0010001000,   // R6
                                        10'b1010000100};  // R7
  localparam string V_REQ [NV] = '{"R1", "R2", "R3", "R4", "R5", "R6", "R7"};

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (opcode=%b)",
               req, what, act, exp, opcode);
    end
  endtask

  function automatic logic [9:0] named_bits();
    return {alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr,
            branch, jump, jump_reg, alu_op};
  endfunction

  function automatic int find_vec(input logic [6:0] op);
    for (int k = 0; k < NV; k++) if (V_OPC[k] == op) return k;
    return -1;
  endfunction

  initial begin
    opcode = 7'b0000000;
    rst_n  = 1'b0;
    repeat (3) @(posedge clk);
    // reset state: opcode 0 is not supported (R8)
    @(negedge clk);
    check("R8", "reset bus", {22'd0, bus}, 32'd0);
    check("R8", "reset illegal", {31'd0, illegal}, 32'd1);
    rst_n = 1'b1;

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      opcode = V_OPC[i];
      @(negedge clk);
      check(V_REQ[i], "bus", {22'd0, bus}, {22'd0, V_BUS[i]});
      check("R9", "named outputs vs bus", {22'd0, named_bits()}, {22'd0, V_BUS[i]});
      check("R8", "illegal low", {31'd0, illegal}, 32'd0);
    end

    // R11: change opcode mid-cycle, outputs follow without a clock edge
    @(negedge clk);
    opcode = 7'b1100111;
    #0.5;
    check("R11", "same-cycle jalr", {22'd0, bus}, {22'd0, V_BUS[6]});
    opcode = 7'b0100011;
    #0.5;
    check("R11", "same-cycle store", {22'd0, bus}, {22'd0, V_BUS[3]});

    // near misses: one bit away from each supported opcode (R8)
    for (int i = 0; i < NV; i++) begin
      for (int b = 0; b < 7; b++) begin
        logic [6:0] nm;
        nm = V_OPC[i] ^ (7'd1 << b);
        if (find_vec(nm) < 0) begin
          @(posedge clk);
          opcode = nm;
          @(negedge clk);
          check("R8", "near-miss bus", {22'd0, bus}, 32'd0);
          check("R8", "near-miss illegal", {31'd0, illegal}, 32'd1);
        end
      end
    end

    // exhaustive sweep of all opcodes (R8, R9, R10)
    for (int op = 0; op < 128; op++) begin
      int idx;
      @(posedge clk);
      opcode = op[6:0];
      @(negedge clk);
      idx = find_vec(op[6:0]);
      if (idx < 0) begin
        check("R8", "sweep bus", {22'd0, bus}, 32'd0);
        check("R8", "sweep illegal", {31'd0, illegal}, 32'd1);
      end else begin
        check(V_REQ[idx], "sweep bus", {22'd0, bus}, {22'd0, V_BUS[idx]});
        check("R8", "sweep legal", {31'd0, illegal}, 32'd0);
      end
      check("R9", "sweep order", {22'd0, named_bits()}, {22'd0, bus});
      check("R10", "redirect exclusive",
            {31'd0, ((32'(branch) + 32'(jump) + 32'(jump_reg)) <= 1)}, 32'd1);
      check("R10", "mem exclusive", {31'd0, mem_rd & mem_wr}, 32'd0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule